// File: doc/BRIEF.md
# Top-K Zero-Crossing Peak Tracker

This block watches a stream of signed per-column scores, the output of an upstream peak-shaping filter. It looks for places where the score drops from a positive value to zero or below between two neighbouring samples of the same row. Each such drop marks the centre of a peak, so it is a lane candidate. The size of the drop measures how strong the candidate is. The block keeps the strongest candidates of the current band of rows in a small table, sorted by strength.

A band opens with a sample flagged as band start and closes with a sample flagged as band end. On the band-end sample, the table is handed to an output serializer and the tracking table is emptied. On the following cycles the serializer presents one slot per clock, strongest first. Slots that hold no candidate are still presented, but with the candidate flag low. Downstream logic that fits lanes reads these slots, band after band.

Top module: `zc_topk_tracker`

## Requirements
- R1: A crossing is detected when a sample is strictly positive and the next accepted sample of the same row is zero or negative; a drop from zero or below, or a rise, is not a crossing.
- R2: A crossing's strength is the earlier sample minus the later sample (always at least 1), and its recorded column is the column of the earlier sample.
- R3: The table keeps at most SLOTS crossings per band, those of largest strength; a new crossing displaces a stored one only when strictly stronger, so among equal strengths the earlier-detected crossings are kept and listed first.
- R4: When a sample with the band-end flag is accepted, out_valid is high for exactly SLOTS cycles starting the next cycle, one slot per cycle, in non-increasing strength order.
- R5: A slot with no candidate is output with out_hit = 0 and out_col and out_mag both 0; out_hit is never high while out_valid is low.
- R6: A sample flagged band start belongs to the new band and any crossings held from an unfinished band are discarded; the band-end sample itself is part of its band, and the table is empty afterwards.
- R7: A sample flagged row start (band start also counts as a row start) cannot complete a crossing with the sample before it.
- R8: While in_valid is low, the sample, column and all flags are ignored: no crossing, no clearing and no output is caused.
- R9: After reset out_valid and out_hit are low and the table is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample strobe; all other inputs are qualified by it |
| in_sample | input | SMP_W | Signed filtered score |
| in_col | input | COL_W | Column index of the sample |
| in_row_start | input | 1 | Sample is the first of a row |
| in_band_start | input | 1 | Sample is the first of a band |
| in_band_end | input | 1 | Sample is the last of a band |
| out_valid | output | 1 | A result slot is presented |
| out_hit | output | 1 | The presented slot holds a candidate |
| out_col | output | COL_W | Column of the candidate |
| out_mag | output | SMP_W+1 | Strength of the candidate (unsigned) |

## Verification
The bench builds the tracker with three slots, 5-bit samples and 4-bit columns. With 5-bit samples every ordered pair of sample values, all 1024 of them, can be swept as a two-sample band, so the crossing rule and the strength arithmetic are covered at both ends of the signed range. Three slots are few enough that the random bands, and a dedicated band of equal-strength crossings, overflow the table again and again, which exercises displacement, tie handling and empty-slot output. Row breaks, idle cycles carrying garbage flags, and abandoned bands are mixed into the stimulus.

// File: rtl/zc_tracker_pkg.sv
package zc_tracker_pkg;
    // Shared default configuration of the tracker and its parts.
    localparam int DEF_SLOTS = 7;
    localparam int DEF_SMP_W = 12;
    localparam int DEF_COL_W = 10;
endpackage

// File: rtl/zc_cross_detect.sv
module zc_cross_detect
    import zc_tracker_pkg::*;
#(
    parameter int SMP_W = DEF_SMP_W,
    parameter int COL_W = DEF_COL_W,
    parameter int MAG_W = DEF_SMP_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [SMP_W-1:0] in_sample,
    input  logic [COL_W-1:0] in_col,
    input  logic             in_first,
    output logic             hit,
    output logic [COL_W-1:0] hit_col,
    output logic [MAG_W-1:0] hit_mag
);
    typedef struct packed {
        logic             have;
        logic [SMP_W-1:0] smp;
        logic [COL_W-1:0] col;
    } prev_t;

    prev_t prev_d, prev_q;
    logic signed [SMP_W:0] diff;

    always_comb begin
        prev_d  = prev_q;
        diff    = $signed({prev_q.smp[SMP_W-1], prev_q.smp})
                - $signed({in_sample[SMP_W-1], in_sample});
        hit     = 1'b0;
        hit_col = prev_q.col;
        hit_mag = MAG_W'(diff);
        if (in_valid) begin
            // A crossing needs a positive sample followed by a non-positive one in the same row.
            if (prev_q.have && !in_first &&
                ($signed(prev_q.smp) > 0) && ($signed(in_sample) <= 0)) begin
                hit = 1'b1;
            end
            prev_d.have = 1'b1;
            prev_d.smp  = in_sample;
            prev_d.col  = in_col;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/zc_rank_table.sv
module zc_rank_table
    import zc_tracker_pkg::*;
#(
    parameter int SLOTS = DEF_SLOTS,
    parameter int COL_W = DEF_COL_W,
    parameter int MAG_W = DEF_SMP_W + 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear,
    input  logic                         snap,
    input  logic                         ins_en,
    input  logic [COL_W-1:0]             ins_col,
    input  logic [MAG_W-1:0]             ins_mag,
    output logic [SLOTS-1:0]             res_used,
    output logic [SLOTS-1:0][COL_W-1:0]  res_col,
    output logic [SLOTS-1:0][MAG_W-1:0]  res_mag
);
    typedef struct packed {
        logic [SLOTS-1:0]            used;
        logic [SLOTS-1:0][COL_W-1:0] col;
        logic [SLOTS-1:0][MAG_W-1:0] mag;
    } tbl_t;

    tbl_t tbl_d, tbl_q, base, res;

    always_comb begin
        int pos;
        base = clear ? '0 : tbl_q;
        // Slot 0 holds the strongest entry; empties sit at the tail.
        pos = SLOTS;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (!base.used[i] || (ins_mag > base.mag[i])) pos = i;
        end
        res = base;
        for (int i = 1; i < SLOTS; i++) begin
            if (ins_en && (i > pos)) begin
                res.used[i] = base.used[i-1];
                res.col[i]  = base.col[i-1];
                res.mag[i]  = base.mag[i-1];
            end
        end
        for (int i = 0; i < SLOTS; i++) begin
            if (ins_en && (i == pos)) begin
                res.used[i] = 1'b1;
                res.col[i]  = ins_col;
                res.mag[i]  = ins_mag;
            end
        end
        tbl_d    = snap ? '0 : res;
        res_used = res.used;
        res_col  = res.col;
        res_mag  = res.mag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end
endmodule

// File: rtl/zc_rank_dump.sv
module zc_rank_dump
    import zc_tracker_pkg::*;
#(
    parameter int SLOTS = DEF_SLOTS,
    parameter int COL_W = DEF_COL_W,
    parameter int MAG_W = DEF_SMP_W + 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         snap,
    input  logic [SLOTS-1:0]             load_used,
    input  logic [SLOTS-1:0][COL_W-1:0]  load_col,
    input  logic [SLOTS-1:0][MAG_W-1:0]  load_mag,
    output logic                         out_valid,
    output logic                         out_hit,
    output logic [COL_W-1:0]             out_col,
    output logic [MAG_W-1:0]             out_mag
);
    localparam int CNT_W = $clog2(SLOTS + 1);

    typedef struct packed {
        logic [CNT_W-1:0]            left;
        logic [SLOTS-1:0]            used;
        logic [SLOTS-1:0][COL_W-1:0] col;
        logic [SLOTS-1:0][MAG_W-1:0] mag;
    } dump_t;

    dump_t dump_d, dump_q;

    always_comb begin
        dump_d = dump_q;
        if (snap) begin
            dump_d.left = CNT_W'(SLOTS);
            dump_d.used = load_used;
            dump_d.col  = load_col;
            dump_d.mag  = load_mag;
        end else if (dump_q.left != '0) begin
            dump_d.left = dump_q.left - 1'b1;
            dump_d.used = dump_q.used >> 1;
            dump_d.col  = dump_q.col >> COL_W;
            dump_d.mag  = dump_q.mag >> MAG_W;
        end
        out_valid = (dump_q.left != '0);
        out_hit   = out_valid && dump_q.used[0];
        out_col   = out_hit ? dump_q.col[0] : '0;
        out_mag   = out_hit ? dump_q.mag[0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dump_q <= '0;
        else        dump_q <= dump_d;
    end
endmodule

// File: rtl/zc_topk_tracker.sv
module zc_topk_tracker
    import zc_tracker_pkg::*;
#(
    parameter int SLOTS = DEF_SLOTS,
    parameter int SMP_W = DEF_SMP_W,
    parameter int COL_W = DEF_COL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [SMP_W-1:0] in_sample,
    input  logic [COL_W-1:0] in_col,
    input  logic             in_row_start,
    input  logic             in_band_start,
    input  logic             in_band_end,
    output logic             out_valid,
    output logic             out_hit,
    output logic [COL_W-1:0] out_col,
    output logic [SMP_W:0]   out_mag
);
    localparam int MAG_W = SMP_W + 1;

    logic                        first_w, clear_w, snap_w;
    logic                        hit_w;
    logic [COL_W-1:0]            hit_col_w;
    logic [MAG_W-1:0]            hit_mag_w;
    logic [SLOTS-1:0]            res_used_w;
    logic [SLOTS-1:0][COL_W-1:0] res_col_w;
    logic [SLOTS-1:0][MAG_W-1:0] res_mag_w;

    assign first_w = in_row_start || in_band_start;
    assign clear_w = in_valid && in_band_start;
    assign snap_w  = in_valid && in_band_end;

    zc_cross_detect #(.SMP_W(SMP_W), .COL_W(COL_W), .MAG_W(MAG_W)) u_det (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .in_col(in_col), .in_first(first_w),
        .hit(hit_w), .hit_col(hit_col_w), .hit_mag(hit_mag_w)
    );

    zc_rank_table #(.SLOTS(SLOTS), .COL_W(COL_W), .MAG_W(MAG_W)) u_tbl (
        .clk(clk), .rst_n(rst_n), .clear(clear_w), .snap(snap_w),
        .ins_en(hit_w), .ins_col(hit_col_w), .ins_mag(hit_mag_w),
        .res_used(res_used_w), .res_col(res_col_w), .res_mag(res_mag_w)
    );

    zc_rank_dump #(.SLOTS(SLOTS), .COL_W(COL_W), .MAG_W(MAG_W)) u_dump (
        .clk(clk), .rst_n(rst_n), .snap(snap_w),
        .load_used(res_used_w), .load_col(res_col_w), .load_mag(res_mag_w),
        .out_valid(out_valid), .out_hit(out_hit), .out_col(out_col), .out_mag(out_mag)
    );
endmodule

// File: rtl/zc_topk_tracker_chk.sv
module zc_topk_tracker_chk #(
    parameter int SLOTS = 7,
    parameter int SMP_W = 12,
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_band_end,
    input logic             out_valid,
    input logic             out_hit,
    input logic [COL_W-1:0] out_col,
    input logic [SMP_W:0]   out_mag
);
    localparam int RUN_W = $clog2(SLOTS + 1) + 1;

    logic             snap_c;
    logic [RUN_W-1:0] run_q;

    assign snap_c = in_valid && in_band_end;

    // Length of the current output burst, measured outside the design.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      run_q <= '0;
        else if (snap_c)                 run_q <= '0;
        else if (out_valid && run_q < RUN_W'(SLOTS)) run_q <= run_q + 1'b1;
        else if (!out_valid)             run_q <= '0;
    end

    p_dump_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        snap_c |=> out_valid);

    p_dump_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (run_q < RUN_W'(SLOTS)));

    p_sorted_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid) && !$past(snap_c))
        |-> (!out_hit || ($past(out_hit) && ($past(out_mag) >= out_mag))));

    p_empty_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_hit) |-> (out_col == '0 && out_mag == '0));

    p_hit_qual_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !out_hit);

    p_mag_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_hit) |-> (out_mag != '0));
endmodule

bind zc_topk_tracker zc_topk_tracker_chk #(
    .SLOTS(SLOTS), .SMP_W(SMP_W), .COL_W(COL_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_band_end(in_band_end),
    .out_valid(out_valid), .out_hit(out_hit), .out_col(out_col), .out_mag(out_mag)
);

// File: tb/zc_topk_tracker_tb_top.sv
module zc_topk_tracker_tb_top;
    localparam int KS = 3;
    localparam int SW = 5;
    localparam int CW = 4;
    localparam int MAXN = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [SW-1:0] in_sample = '0;
    logic [CW-1:0] in_col = '0;
    logic          in_row_start = 1'b0;
    logic          in_band_start = 1'b0;
    logic          in_band_end = 1'b0;
    logic          out_valid, out_hit;
    logic [CW-1:0] out_col;
    logic [SW:0]   out_mag;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int nsmp;
    int smp_a [MAXN];
    int col_a [MAXN];
    bit rs_a  [MAXN];
    int n_exp;
    int exp_col [KS];
    int exp_mag [KS];

    always #4 clk = ~clk;

    zc_topk_tracker #(.SLOTS(KS), .SMP_W(SW), .COL_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .in_col(in_col), .in_row_start(in_row_start), .in_band_start(in_band_start),
        .in_band_end(in_band_end), .out_valid(out_valid), .out_hit(out_hit),
        .out_col(out_col), .out_mag(out_mag)
    );

    task automatic check(bit ok, string req, string what, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Expected result from the requirements: list all crossings, then pick the
    // strongest with the earliest one winning ties.
    task automatic model();
        int cr_col [MAXN];
        int cr_mag [MAXN];
        bit taken  [MAXN];
        int ncr = 0;
        for (int i = 1; i < nsmp; i++) begin
            if (!rs_a[i] && smp_a[i-1] > 0 && smp_a[i] <= 0) begin
                cr_col[ncr] = col_a[i-1];
                cr_mag[ncr] = smp_a[i-1] - smp_a[i];
                taken[ncr]  = 1'b0;
                ncr++;
            end
        end
        n_exp = 0;
        for (int j = 0; j < KS; j++) begin
            int best = -1;
            for (int m = 0; m < ncr; m++) begin
                if (!taken[m] && (best < 0 || cr_mag[m] > cr_mag[best])) best = m;
            end
            if (best >= 0) begin
                taken[best] = 1'b1;
                exp_col[n_exp] = cr_col[best];
                exp_mag[n_exp] = cr_mag[best];
                n_exp++;
            end
        end
    endtask

    task automatic idle_garbage();
        in_valid      = 1'b0;
        in_sample     = SW'($urandom);
        in_col        = CW'($urandom);
        in_row_start  = 1'($urandom);
        in_band_start = 1'($urandom);
        in_band_end   = 1'($urandom);
    endtask

    task automatic drive_band(bit with_end, bit gaps);
        for (int i = 0; i < nsmp; i++) begin
            if (gaps && i > 0 && ($urandom_range(3) == 0)) begin
                @(negedge clk);
                idle_garbage();  // R8: ignored while in_valid is low
            end
            @(negedge clk);
            in_valid      = 1'b1;
            in_sample     = SW'(smp_a[i]);
            in_col        = CW'(col_a[i]);
            in_row_start  = rs_a[i];
            in_band_start = (i == 0);
            in_band_end   = with_end && (i == nsmp - 1);
        end
        @(negedge clk);
        in_valid      = 1'b0;
        in_band_start = 1'b0;
        in_band_end   = 1'b0;
        in_row_start  = 1'b0;
    endtask

    task automatic check_dump(string req);
        for (int j = 0; j < KS; j++) begin
            if (j > 0) @(negedge clk);
            check(out_valid == 1'b1, "R4", {req, " out_valid in burst"}, int'(out_valid), 1);
            check(out_hit == (j < n_exp), "R5", {req, " out_hit"}, int'(out_hit), int'(j < n_exp));
            if (j < n_exp) begin
                check(int'(out_col) == exp_col[j], "R2", {req, " out_col"}, int'(out_col), exp_col[j]);
                check(int'(out_mag) == exp_mag[j], "R3", {req, " out_mag"}, int'(out_mag), exp_mag[j]);
            end else begin
                check(out_col == '0 && out_mag == '0, "R5", {req, " empty slot fields"},
                      int'(out_mag), 0);
            end
        end
        @(negedge clk);
        check(out_valid == 1'b0, "R4", {req, " burst length"}, int'(out_valid), 0);
    endtask

    task automatic run_band(string req, bit gaps);
        model();
        drive_band(1'b1, gaps);
        check_dump(req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0 && out_hit == 1'b0, "R9", "reset outputs", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R9", "idle after reset", int'(out_valid), 0);

        // R1 R2: every ordered pair of 5-bit values as a two-sample band.
        for (int a = -16; a < 16; a++) begin
            for (int b = -16; b < 16; b++) begin
                nsmp = 2;
                smp_a[0] = a; smp_a[1] = b;
                col_a[0] = (a + 16) % 16; col_a[1] = (b + 16) % 16;
                rs_a[0] = 1'b1; rs_a[1] = 1'b0;
                run_band("R1 pair sweep", 1'b0);
            end
        end

        // R7: the same drop split across a row boundary is not a crossing.
        nsmp = 4;
        smp_a[0] = 2;  smp_a[1] = 7; smp_a[2] = -3; smp_a[3] = -1;
        col_a[0] = 0;  col_a[1] = 1; col_a[2] = 0;  col_a[3] = 1;
        rs_a[0] = 1'b1; rs_a[1] = 1'b0; rs_a[2] = 1'b1; rs_a[3] = 1'b0;
        run_band("R7 row break", 1'b0);

        // R3: four equal crossings plus one stronger; earliest equal ones stay.
        nsmp = 10;
        for (int i = 0; i < 8; i++) begin
            smp_a[i] = (i % 2 == 0) ? 4 : -1;
            col_a[i] = i;
            rs_a[i]  = (i == 0);
        end
        smp_a[8] = 9; col_a[8] = 8; rs_a[8] = 1'b0;
        smp_a[9] = 0; col_a[9] = 9; rs_a[9] = 1'b0;
        run_band("R3 ties", 1'b0);

        // R6: an abandoned band leaves nothing behind for the next band.
        nsmp = 6;
        for (int i = 0; i < nsmp; i++) begin
            smp_a[i] = (i % 2 == 0) ? 15 : -16;
            col_a[i] = i;
            rs_a[i]  = (i == 0);
        end
        drive_band(1'b0, 1'b0);
        check(out_valid == 1'b0, "R6", "no output without band end", int'(out_valid), 0);
        nsmp = 3;
        smp_a[0] = 1; smp_a[1] = 2; smp_a[2] = 0;
        col_a[0] = 3; col_a[1] = 4; col_a[2] = 5;
        rs_a[0] = 1'b1; rs_a[1] = 1'b0; rs_a[2] = 1'b0;
        run_band("R6 fresh band", 1'b0);

        // R8: idle cycles with garbage flags produce no output.
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            idle_garbage();
            check(out_valid == 1'b0, "R8", "idle garbage", int'(out_valid), 0);
        end
        @(negedge clk);
        in_band_end = 1'b0;
        in_band_start = 1'b0;

        // R3 R4 R5 R7 R8: random bands with rows and gaps.
        for (int t = 0; t < 400; t++) begin
            int rowlen = 2 + int'($urandom_range(6));
            nsmp = 4 + int'($urandom_range(MAXN - 4));
            for (int i = 0; i < nsmp; i++) begin
                smp_a[i] = int'($urandom_range(31)) - 16;
                col_a[i] = i % rowlen;
                rs_a[i]  = (i % rowlen == 0);
            end
            run_band("R3 random band", 1'b1);
        end

        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R4 watchdog: actual %0d expected %0d", 0, 1);
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule